// File: doc/BRIEF.md
# Fractional Master and Bit Clock Divider

This block derives two audio timing strobes from a fast source clock. The first, the master-clock strobe, marks the end of every master period. A period lasts an integer number of source cycles plus, on average, a fraction num/den of a cycle. The second, the bit-clock strobe, marks every bdiv-th master period. Both strobes are one source cycle wide and are registered, so downstream logic can use them as clock enables or toggle a flop on them to form a square wave.

The fraction is realised with an error accumulator. At the start of each master period the numerator is added to the accumulator. If the sum reaches the denominator or more, the denominator is subtracted and that period is one source cycle longer. Setting den = 1 and num = 0 gives pure integer division. Every divisor is sampled only when a new period begins, so a mid-period change never shortens or splits the period in flight.

Top module: `frac_clk_div`

## Requirements
- R1: While rst is high or en is low, mclk_tick and bclk_tick stay 0 and the counters and accumulator clear. When en is sampled high at a source edge, the first mclk_tick appears exactly N source edges later, where N is the effective integer divisor.
- R2: With den = 1 and num = 0, consecutive mclk_tick pulses are exactly N source cycles apart.
- R3: With 2 <= den <= 63 and 0 < num < den, each period is N or N+1 cycles. The accumulator starts at 0. For each period, s = acc + num; if s >= den the period is N+1 and acc becomes s - den, otherwise the period is N and acc becomes s. Over the first den periods exactly num are stretched.
- R4: An int_div value of 0 or 1 is treated as 2, so the effective divisor N is max(int_div, 2).
- R5: bclk_tick is high only in a cycle where mclk_tick is high. It occurs on every bdiv-th mclk_tick, counting from enable, and a bdiv of 0 is treated as 1.
- R6: A change of int_div, num, den or bdiv takes effect only for a period that starts after the change. The period in flight keeps its length.
- R7: A fraction with den < 2 or num >= den is treated as num = 0, giving pure integer division.
- R8: When the sampled fraction differs from the one used for the previous period, the accumulator restarts from 0 before adding the new numerator.
- R9: Each mclk_tick and bclk_tick pulse is exactly one source cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears the divider state |
| int_div | input | IW | Integer part of the master divisor |
| frac_num | input | 6 | Fraction numerator |
| frac_den | input | 6 | Fraction denominator |
| bclk_div | input | BW | Bit-clock divisor counted in master periods |
| mclk_tick | output | 1 | One-cycle strobe at each master period end |
| bclk_tick | output | 1 | One-cycle strobe at each bit-clock period end |

## Verification
A wrong accumulator value never shows up as a wrong period length at once. It shows as a stretched period in the wrong slot of the den-period sequence, so the bench compares every measured gap against an independent accumulator model. A single misplaced stretch is caught at the next strobe. A stale or early-loaded divisor shows within one period of the change as a gap of the wrong length. A bit-clock counter fault shows within bdiv master periods as a bit strobe on the wrong master tick, or one that does not coincide with a master tick.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    localparam int FRAC_W = 6;

    typedef struct packed {
        logic [FRAC_W-1:0] num;
        logic [FRAC_W-1:0] den;
    } frac_t;

    typedef struct packed {
        logic              stretch;
        logic [FRAC_W-1:0] acc;
    } step_t;

    // An unusable fraction collapses to integer division.
    function automatic frac_t frac_clean(frac_t f);
        frac_t r;
        r = f;
        if ((f.den < FRAC_W'(2)) || (f.num >= f.den)) begin
            r.num = '0;
        end
        return r;
    endfunction

    // One accumulator step for a period start.
    function automatic step_t frac_step(logic [FRAC_W-1:0] acc, frac_t f);
        step_t             r;
        logic [FRAC_W:0]   sum;
        sum = {1'b0, acc} + {1'b0, f.num};
        if ((f.num != '0) && (sum >= {1'b0, f.den})) begin
            r.stretch = 1'b1;
            r.acc     = FRAC_W'(sum - {1'b0, f.den});
        end else begin
            r.stretch = 1'b0;
            r.acc     = FRAC_W'(sum);
        end
        return r;
    endfunction

endpackage

// File: rtl/fdiv_mclk_stage.sv
module fdiv_mclk_stage
    import fdiv_pkg::*;
#(
    parameter int IW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [IW-1:0] int_div,
    input  frac_t         frac_in,
    output logic          period_end,
    output logic          tick
);

    localparam int CW = IW + 1;

    logic          running_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] len_q;
    logic [FRAC_W-1:0] acc_q;
    frac_t         frac_q;

    logic [CW-1:0] n_eff;
    frac_t         frac_c;
    logic [FRAC_W-1:0] acc_base;
    step_t         step;
    logic          load;

    always_comb begin
        n_eff    = (int_div < IW'(2)) ? CW'(2) : {1'b0, int_div};
        frac_c   = frac_clean(frac_in);
        acc_base = (frac_c != frac_q) ? '0 : acc_q;
        step     = frac_step(acc_base, frac_c);
        period_end = running_q && (cnt_q == (len_q - CW'(1)));
        load     = en && (!running_q || period_end);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
            len_q     <= '0;
            acc_q     <= '0;
            frac_q    <= '0;
            tick      <= 1'b0;
        end else begin
            tick <= period_end;
            if (load) begin
                running_q <= 1'b1;
                cnt_q     <= '0;
                len_q     <= n_eff + CW'(step.stretch);
                acc_q     <= step.acc;
                frac_q    <= frac_c;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

endmodule

// File: rtl/fdiv_bclk_stage.sv
module fdiv_bclk_stage #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [BW-1:0] bclk_div,
    input  logic          mclk_end,
    output logic          tick
);

    logic          running_q;
    logic [BW-1:0] bcnt_q;
    logic [BW-1:0] bdiv_q;
    logic [BW-1:0] bdiv_eff;
    logic          wrap;

    always_comb begin
        bdiv_eff = (bclk_div == '0) ? BW'(1) : bclk_div;
        wrap     = running_q && mclk_end && (bcnt_q == (bdiv_q - BW'(1)));
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            running_q <= 1'b0;
            bcnt_q    <= '0;
            bdiv_q    <= '0;
            tick      <= 1'b0;
        end else if (!running_q) begin
            running_q <= 1'b1;
            bcnt_q    <= '0;
            bdiv_q    <= bdiv_eff;
            tick      <= 1'b0;
        end else if (wrap) begin
            bcnt_q <= '0;
            bdiv_q <= bdiv_eff;
            tick   <= 1'b1;
        end else begin
            if (mclk_end) begin
                bcnt_q <= bcnt_q + BW'(1);
            end
            tick <= 1'b0;
        end
    end

endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
    import fdiv_pkg::*;
#(
    parameter int IW = 8,
    parameter int BW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [IW-1:0]     int_div,
    input  logic [FRAC_W-1:0] frac_num,
    input  logic [FRAC_W-1:0] frac_den,
    input  logic [BW-1:0]     bclk_div,
    output logic              mclk_tick,
    output logic              bclk_tick
);

    frac_t frac_in;
    logic  mclk_end;

    assign frac_in = '{num: frac_num, den: frac_den};

    fdiv_mclk_stage #(.IW(IW)) u_mclk (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .int_div    (int_div),
        .frac_in    (frac_in),
        .period_end (mclk_end),
        .tick       (mclk_tick)
    );

    fdiv_bclk_stage #(.BW(BW)) u_bclk (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .bclk_div (bclk_div),
        .mclk_end (mclk_end),
        .tick     (bclk_tick)
    );

endmodule

// File: rtl/frac_clk_div_chk.sv
module frac_clk_div_chk #(
    parameter int IW = 8
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic mclk_tick,
    input logic bclk_tick
);

    localparam int GW = IW + 2;

    logic [GW-1:0] gap_q;
    logic          seen_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (mclk_tick) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != {GW{1'b1}}) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!mclk_tick && !bclk_tick));

    assert_gap_range_R3: assert property (@(posedge clk) disable iff (rst)
        (mclk_tick && seen_q && en) |->
            ((gap_q >= GW'(1)) && (gap_q <= GW'((1 << IW) - 1))));

    assert_bclk_on_mclk_R5: assert property (@(posedge clk) disable iff (rst)
        bclk_tick |-> mclk_tick);

    assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
        mclk_tick |=> !mclk_tick);

endmodule

bind frac_clk_div frac_clk_div_chk #(.IW(IW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .mclk_tick (mclk_tick),
    .bclk_tick (bclk_tick)
);

// File: tb/tb_frac_clk_div.sv
`timescale 1ns/1ps
module tb_frac_clk_div;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [7:0] int_div = 8'd4;
    logic [5:0] frac_num = 6'd0;
    logic [5:0] frac_den = 6'd1;
    logic [7:0] bclk_div = 8'd1;
    logic       mclk_tick;
    logic       bclk_tick;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frac_clk_div dut (
        .clk(clk), .rst(rst), .en(en), .int_div(int_div),
        .frac_num(frac_num), .frac_den(frac_den), .bclk_div(bclk_div),
        .mclk_tick(mclk_tick), .bclk_tick(bclk_tick)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic next_gap(output int g);
        g = 0;
        do begin
            @(negedge clk);
            g++;
        end while (!mclk_tick && g < 1000);
    endtask

    task automatic restart(int n, int a, int b, int bd);
        en = 1'b0;
        repeat (2) @(negedge clk);
        int_div = 8'(n); frac_den = 6'(a); frac_num = 6'(b); bclk_div = 8'(bd);
        en = 1'b1;
    endtask

    // Runs from enable and compares every gap with the accumulator model.
    task automatic run_seq(int n, int a, int b, int cnt, string tag);
        int acc = 0, ne, bb, g, s, st, len, nstr = 0;
        ne = (n < 2) ? 2 : n;
        bb = (a < 2 || b >= a) ? 0 : b;
        restart(n, a, b, 1);
        for (int k = 0; k < cnt; k++) begin
            next_gap(g);
            s = acc + bb;
            st = (bb != 0 && s >= a) ? 1 : 0;
            acc = st ? s - a : s;
            len = ne + st;
            check(tag, g, (k == 0) ? len + 1 : len);
            if (k < a && ((k == 0 ? g - 1 : g) > ne)) nstr++;
        end
        if (bb != 0 && cnt >= a) check({tag, " stretch count"}, nstr, bb);
    endtask

    task automatic t_reset();
        int bad = 0;
        rst = 1'b1; en = 1'b1; int_div = 8'd2;
        repeat (8) begin
            @(negedge clk);
            if (mclk_tick || bclk_tick) bad++;
        end
        check("R1 reset quiet", bad, 0);
        en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_disable();
        int g, bad = 0;
        restart(5, 1, 0, 1);
        next_gap(g);
        check("R1 first gap", g, 6);
        repeat (2) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        repeat (12) begin
            @(negedge clk);
            if (mclk_tick || bclk_tick) bad++;
        end
        check("R1 disabled quiet", bad, 0);
        en = 1'b1;
        next_gap(g);
        check("R1 restart gap", g, 6);
    endtask

    task automatic t_change_int();
        int g;
        restart(6, 1, 0, 1);
        next_gap(g); check("R6 first", g, 7);
        next_gap(g); check("R6 before", g, 6);
        int_div = 8'd9;
        next_gap(g); check("R6 in flight", g, 6);
        next_gap(g); check("R6 applied", g, 9);
    endtask

    task automatic t_change_frac();
        int g;
        int exp_new[5] = '{4, 4, 5, 4, 5};
        restart(4, 3, 1, 1);
        next_gap(g); check("R8 old p0", g, 5);
        next_gap(g); check("R8 old p1", g, 4);
        frac_den = 6'd5; frac_num = 6'd2;
        next_gap(g); check("R8 old p2 in flight", g, 5);
        for (int k = 0; k < 5; k++) begin
            next_gap(g);
            check("R8 new sequence", g, exp_new[k]);
        end
    endtask

    task automatic t_bclk(int bd, string tag);
        int mcount = 0, seen = 0, miss = 0, ebd;
        ebd = (bd == 0) ? 1 : bd;
        restart(3, 1, 0, bd);
        for (int c = 0; c < 400 && seen < 3; c++) begin
            @(negedge clk);
            if (bclk_tick && !mclk_tick) miss++;
            if (mclk_tick) mcount++;
            if (bclk_tick) begin
                check({tag, " bclk spacing"}, mcount, ebd);
                mcount = 0;
                seen++;
            end
        end
        check({tag, " bclk count"}, seen, 3);
        check({tag, " bclk coincident"}, miss, 0);
    endtask

    task automatic t_width();
        int g;
        restart(5, 1, 0, 1);
        next_gap(g);
        @(negedge clk);
        check("R9 mclk width", int'(mclk_tick), 0);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        t_reset();
        run_seq(5, 1, 0, 6, "R2");
        run_seq(8, 1, 0, 4, "R2");
        run_seq(4, 3, 1, 9, "R3");
        run_seq(6, 5, 2, 10, "R3");
        run_seq(3, 63, 62, 64, "R3");
        run_seq(0, 1, 0, 4, "R4");
        run_seq(1, 1, 0, 4, "R4");
        run_seq(5, 4, 5, 5, "R7");
        run_seq(5, 0, 3, 4, "R7");
        t_disable();
        t_change_int();
        t_change_frac();
        t_bclk(3, "R5");
        t_bclk(0, "R5");
        t_width();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule